// File: doc/BRIEF.md
# Timeslot PRBS Generator and Analyzer

This block places a pseudo-random binary test sequence into selected 64 kb/s timeslots of a bit-serial 2048 kb/s frame of 32 timeslots. It also checks a sequence arriving in selected timeslots. It runs on the bit clock. A single-cycle frame-sync pulse marks the first bit of timeslot 0. A free-running bit position then gives the current timeslot, which is the bit position divided by eight. On the transmit side the generator's bits replace the outgoing data in the chosen timeslots, and all other bits pass through unchanged.

On the check side the analyzer reads one of three streams. It predicts each bit from the bits it has already received, so it locks onto the incoming sequence without a separate alignment step. It counts the bits that differ from its prediction in a saturating error counter. That counter is presented as two byte-wide register images and is cleared by a strobe. While the frame is lost the analyzer stops completely. A status flag reports when the sequence has been error-free long enough to count as recovered.

Top module: `ts_prbs_engine`

## Requirements
- R1: After a synchronous reset, `tx_out` is 1, `err_lo` is 8'h80, `err_hi` is 8'h00 and `seq_ok` is 0.
- R2: The cycle with `frame_sync`=1 is bit position 0. Each later cycle is the next position, modulo 256, and the timeslot is position/8. `tx_out` shows, one clock after the inputs are sampled, the transmit bit chosen for that position.
- R3: Slot select encoding applies to `gen_slot` and `ana_slot`: bit 5 = 1 selects all 32 timeslots, otherwise only the timeslot equal to bits 4:0 is selected. In selected timeslots with `gen_en`=1, `tx_out` carries the generator bit. In every other bit it carries `tx_in`.
- R4: The generator implements x^15 + x^14 + 1. Each output bit is the XOR of the generated bits 15 and 14 places earlier. Its history is all ones while `gen_en`=0, and it advances only on inserted bits.
- R5: `ana_src` selects the analyzed stream: 00 = `rx_bit`, 01 = the transmit bit being sent out (after substitution), 10 or 11 = `tx_in`.
- R6: With `ana_en`=1, in each selected timeslot bit the analyzer predicts the XOR of the analyzed bits 15 and 14 places earlier (history all ones after reset). It then takes in the actual bit and adds one to the error count on a mismatch. A single flipped bit in a good sequence therefore costs exactly 3 errors.
- R7: `seq_ok` goes to 1 on the 32nd consecutive error-free analyzed bit. It returns to 0 on an error or when `ana_en`=0.
- R8: While `lof`=1 no bit is analyzed: the count, the history and `seq_ok` hold.
- R9: The 14-bit count is shown as `err_lo` = {1, count[6:0]} and `err_hi` = {0, count[13:7]}. It saturates at 16383.
- R10: `clr_cnt`=1 zeroes the count on that clock edge and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Marks bit 0 of timeslot 0 |
| tx_in | input | 1 | Outgoing data before substitution |
| rx_bit | input | 1 | Received data |
| gen_en | input | 1 | Generator enable |
| gen_slot | input | 6 | Generator timeslot select |
| ana_en | input | 1 | Analyzer enable |
| ana_slot | input | 6 | Analyzer timeslot select |
| ana_src | input | 2 | Analyzer stream select |
| lof | input | 1 | Loss of frame |
| clr_cnt | input | 1 | Clear error count |
| tx_out | output | 1 | Transmit data after substitution |
| err_lo | output | 8 | Flag bit and count bits 6:0 |
| err_hi | output | 8 | Count bits 13:7 |
| seq_ok | output | 1 | Sequence recovered |

## Verification
Some properties are checked by assertions on every cycle. These are: pass-through of `tx_in` when the generator is off, a generator state that never becomes all zeros, a count that stays at its maximum, a count that holds while the frame is lost, clearing by the strobe, and `seq_ok` rising only after a full error-free run. Other behaviour can only be shown by the bench's scenarios against its reference model. This covers the exact generated sequence and where it sits in the frame, the three analyzer sources, the cost of three errors for each flipped bit, and the count reaching saturation under continuous errors.

// File: rtl/ts_prbs_pkg.sv
package ts_prbs_pkg;
  // Frame geometry: 32 timeslots of 8 bits
  localparam int SLOT_W = 5;
  localparam int BIT_W  = 3;

  typedef enum logic [1:0] {
    SRC_RX     = 2'b00,
    SRC_TXOUT  = 2'b01,
    SRC_TXIN_A = 2'b10,
    SRC_TXIN_B = 2'b11
  } ana_src_e;

  // top bit selects every timeslot, otherwise an exact match
  function automatic logic slot_hit(input logic [SLOT_W:0] sel,
                                    input logic [SLOT_W-1:0] slot);
    return sel[SLOT_W] | (sel[SLOT_W-1:0] == slot);
  endfunction
endpackage

// File: rtl/ts_bit_timer.sv
module ts_bit_timer #(
  parameter int SLOT_W = 5,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_sync,
  output logic [SLOT_W-1:0] slot_o
);
  localparam int POS_W = SLOT_W + BIT_W;

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_cur;

  assign pos_cur = frame_sync ? '0 : pos_q + 1'b1;
  assign slot_o  = pos_cur[POS_W-1 -: SLOT_W];

  always_ff @(posedge clk) begin
    if (rst) pos_q <= '1;
    else     pos_q <= pos_cur;
  end

  AST_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!frame_sync && pos_q == '1) |=> pos_q == '0); // R2
endmodule

// File: rtl/ts_prbs_gen.sv
module ts_prbs_gen #(
  parameter int LFSR_W = 15,
  parameter int TAP_LO = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic step,
  output logic bit_o
);
  logic [LFSR_W-1:0] st;
  logic              fb;

  assign fb    = st[LFSR_W-1] ^ st[TAP_LO-1];
  assign bit_o = fb;

  always_ff @(posedge clk) begin
    if (rst || !en)  st <= '1;
    else if (step)   st <= {st[LFSR_W-2:0], fb};
  end

  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    st != '0); // R4
endmodule

// File: rtl/ts_prbs_chk.sv
module ts_prbs_chk #(
  parameter int LFSR_W   = 15,
  parameter int TAP_LO   = 14,
  parameter int LO_W     = 7,
  parameter int LOCK_RUN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              hit,
  input  logic              lof,
  input  logic              sample,
  input  logic              clr,
  output logic [2*LO_W-1:0] cnt_o,
  output logic              locked_o
);
  localparam int CNT_W = 2 * LO_W;
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOCK_RUN);

  logic [LFSR_W-1:0] hist;
  logic [RUN_W-1:0]  run;
  logic [RUN_W-1:0]  run_inc;
  logic [CNT_W-1:0]  cnt;
  logic              locked;
  logic              active;
  logic              pred;
  logic              miss;

  assign active  = en & hit & ~lof;
  assign pred    = hist[LFSR_W-1] ^ hist[TAP_LO-1];
  assign miss    = sample ^ pred;
  assign run_inc = (run == RUN_MAX) ? run : run + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist   <= '1;
      run    <= '0;
      locked <= 1'b0;
      cnt    <= '0;
    end else begin
      if (active) hist <= {hist[LFSR_W-2:0], sample};

      if (!en) begin
        run    <= '0;
        locked <= 1'b0;
      end else if (active) begin
        if (miss) begin
          run    <= '0;
          locked <= 1'b0;
        end else begin
          run    <= run_inc;
          locked <= (run_inc == RUN_MAX);
        end
      end

      if (clr)                           cnt <= '0;
      else if (active && miss && cnt != '1) cnt <= cnt + 1'b1;
    end
  end

  assign cnt_o    = cnt;
  assign locked_o = locked;

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    (cnt == '1 && !clr) |=> cnt == '1); // R9
  AST_LOF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (lof && !clr) |=> $stable(cnt)); // R8
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0); // R10
  AST_LOCK_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> run == RUN_MAX); // R7
endmodule

// File: rtl/ts_prbs_engine.sv
module ts_prbs_engine
  import ts_prbs_pkg::*;
#(
  parameter int LFSR_W   = 15,
  parameter int TAP_LO   = 14,
  parameter int LO_W     = 7,
  parameter int LOCK_RUN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_sync,
  input  logic            tx_in,
  input  logic            rx_bit,
  input  logic            gen_en,
  input  logic [SLOT_W:0] gen_slot,
  input  logic            ana_en,
  input  logic [SLOT_W:0] ana_slot,
  input  logic [1:0]      ana_src,
  input  logic            lof,
  input  logic            clr_cnt,
  output logic            tx_out,
  output logic [LO_W:0]   err_lo,
  output logic [LO_W:0]   err_hi,
  output logic            seq_ok
);
  logic [SLOT_W-1:0] slot;
  logic              gen_bit;
  logic              gen_hit;
  logic              ana_hit;
  logic              tx_next;
  logic              ana_bit;
  logic [2*LO_W-1:0] cnt;

  ts_bit_timer #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_timer (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .slot_o(slot)
  );

  assign gen_hit = gen_en & slot_hit(gen_slot, slot);
  assign ana_hit = slot_hit(ana_slot, slot);

  ts_prbs_gen #(.LFSR_W(LFSR_W), .TAP_LO(TAP_LO)) u_gen (
    .clk(clk), .rst(rst), .en(gen_en), .step(gen_hit), .bit_o(gen_bit)
  );

  assign tx_next = gen_hit ? gen_bit : tx_in;

  always_comb begin
    case (ana_src_e'(ana_src))
      SRC_RX:    ana_bit = rx_bit;
      SRC_TXOUT: ana_bit = tx_next;
      default:   ana_bit = tx_in;
    endcase
  end

  ts_prbs_chk #(.LFSR_W(LFSR_W), .TAP_LO(TAP_LO), .LO_W(LO_W), .LOCK_RUN(LOCK_RUN)) u_chk (
    .clk(clk), .rst(rst), .en(ana_en), .hit(ana_hit), .lof(lof),
    .sample(ana_bit), .clr(clr_cnt), .cnt_o(cnt), .locked_o(seq_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_out <= 1'b1;
    else     tx_out <= tx_next;
  end

  assign err_lo = {1'b1, cnt[LO_W-1:0]};
  assign err_hi = {1'b0, cnt[2*LO_W-1:LO_W]};

  AST_TX_PASS: assert property (@(posedge clk) disable iff (rst)
    !gen_en |=> tx_out == $past(tx_in)); // R3
endmodule

// File: tb/ts_prbs_engine_tb.sv
module ts_prbs_engine_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1, frame_sync = 1'b0, tx_in = 1'b0, rx_bit = 1'b0;
  logic       gen_en = 1'b0, ana_en = 1'b0, lof = 1'b0, clr_cnt = 1'b0;
  logic [5:0] gen_slot = 6'd0, ana_slot = 6'd0;
  logic [1:0] ana_src = 2'b00;
  logic       tx_out, seq_ok;
  logic [7:0] err_lo, err_hi;

  ts_prbs_engine u_dut (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .tx_in(tx_in), .rx_bit(rx_bit),
    .gen_en(gen_en), .gen_slot(gen_slot), .ana_en(ana_en), .ana_slot(ana_slot),
    .ana_src(ana_src), .lof(lof), .clr_cnt(clr_cnt), .tx_out(tx_out),
    .err_lo(err_lo), .err_hi(err_hi), .seq_ok(seq_ok)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int m_pos, m_cnt, m_run;
  bit m_tx, m_ok;
  bit q_gen[$], q_ana[$], q_src[$];
  int fcount = 0;
  // bench stimulus modes: 0 none, 1 good PRBS, 2 inverted prediction
  int rx_mode = 0, txin_mode = 0;
  int flip_every = 0, flip_ctr = 0;

  function automatic void fill_ones(ref bit q[$]);
    q.delete();
    for (int i = 0; i < 15; i++) q.push_back(1'b1);
  endfunction

  function automatic bit nxt(ref bit q[$]);
    return q[q.size()-15] ^ q[q.size()-14];
  endfunction

  function automatic void push(ref bit q[$], input bit b);
    q.push_back(b);
    void'(q.pop_front());
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit hit(input logic [5:0] sel, input int slot);
    return sel[5] || (sel[4:0] == slot[4:0]);
  endfunction

  task automatic model_step();
    bit g, txn, smp, pred;
    int slot;
    if (rst) begin
      m_pos = 255; m_cnt = 0; m_run = 0; m_ok = 0; m_tx = 1;
      fill_ones(q_gen); fill_ones(q_ana);
      return;
    end
    m_pos = frame_sync ? 0 : (m_pos + 1) % 256;
    slot = m_pos / 8;
    g = nxt(q_gen);
    txn = (gen_en && hit(gen_slot, slot)) ? g : tx_in;
    if (!gen_en) fill_ones(q_gen);
    else if (hit(gen_slot, slot)) push(q_gen, g);
    m_tx = txn;
    case (ana_src)
      2'b00:   smp = rx_bit;
      2'b01:   smp = txn;
      default: smp = tx_in;
    endcase
    if (!ana_en) begin
      m_run = 0; m_ok = 0;
    end else if (hit(ana_slot, slot) && !lof) begin
      pred = nxt(q_ana);
      push(q_ana, smp);
      if (smp != pred) begin
        m_run = 0; m_ok = 0;
        if (m_cnt < 16383) m_cnt++;
      end else begin
        if (m_run < 32) m_run++;
        m_ok = (m_run == 32);
      end
    end
    if (clr_cnt) m_cnt = 0;
  endtask

  // one bit period: drive, model, sample on the falling edge
  task automatic step();
    bit b, fl;
    frame_sync = (fcount == 0);
    fcount = (fcount + 1) % 256;
    fl = 0;
    if (flip_every > 0) begin
      flip_ctr++;
      if (flip_ctr == flip_every) begin fl = 1; flip_ctr = 0; end
    end
    b = nxt(q_src);
    if (rx_mode == 1) rx_bit = b ^ fl;
    if (rx_mode == 2) rx_bit = ~nxt(q_ana);
    if (txin_mode == 1) tx_in = b;
    if (rx_mode == 1 || txin_mode == 1) push(q_src, b);
    model_step();
    @(negedge clk);
    check(tx_out == m_tx, "R2/R3/R4 tx_out", tx_out, m_tx);
    check(err_lo == {1'b1, 7'(m_cnt)} && err_hi == {1'b0, 7'(m_cnt >> 7)},
          "R6/R9 count", {err_hi, err_lo}, {1'b0, 7'(m_cnt >> 7), 1'b1, 7'(m_cnt)});
    check(seq_ok == m_ok, "R7 seq_ok", seq_ok, m_ok);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    fill_ones(q_src);
    @(negedge clk);
    run(3);
    // R1 reset values
    check(tx_out == 1 && err_lo == 8'h80 && err_hi == 8'h00 && seq_ok == 0,
          "R1 reset", {tx_out, err_hi, err_lo, seq_ok}, 18'h20100);
    rst = 1'b0;
    fcount = 0;

    // R2 R3 R4: generator in slot 5, pass-through elsewhere
    txin_mode = 0;
    gen_en = 1; gen_slot = 6'd5;
    for (int i = 0; i < 600; i++) begin tx_in = (i % 3 == 0); step(); end

    // R5 R7: analyze outgoing bits in the generator slot, lock
    gen_en = 0; step(); gen_en = 1; gen_slot = 6'd7;
    ana_en = 1; ana_slot = 6'd7; ana_src = 2'b01;
    run(256 * 6);
    check(seq_ok == 1, "R7 lock after 32 clean bits", seq_ok, 1);
    check(err_lo == 8'h80 && err_hi == 8'h00, "R6 no errors on clean sequence", err_lo, 8'h80);
    ana_en = 0; step();
    check(seq_ok == 0, "R7 clear on disable", seq_ok, 0);

    // R5 R6: rx path, all slots, isolated flips cost 3 errors each
    gen_en = 0; gen_slot = 6'h20;
    ana_en = 1; ana_slot = 6'h20; ana_src = 2'b00; rx_mode = 1;
    run(300);
    clr_cnt = 1; step(); clr_cnt = 0;
    flip_ctr = 0; flip_every = 100;
    run(1000);
    flip_every = 0;
    run(50);
    check(err_lo == 8'h9E && err_hi == 8'h00, "R6 three errors per flipped bit", err_lo, 8'h9E);

    // R5: tx_in source in a single slot, and generator in all slots to tx_out
    txin_mode = 1; ana_src = 2'b10; ana_slot = 6'd9; gen_en = 1;
    run(512);
    ana_src = 2'b01;
    run(300);

    // R8: loss of frame freezes everything
    txin_mode = 0; ana_src = 2'b00; ana_slot = 6'h20; rx_mode = 2;
    clr_cnt = 1; step(); clr_cnt = 0;
    lof = 1; run(64);
    check(err_lo == 8'h80 && err_hi == 8'h00, "R8 no count during lof", err_lo, 8'h80);
    lof = 0;

    // R9: saturation under continuous errors
    run(16400);
    check(err_lo == 8'hFF && err_hi == 8'h7F, "R9 saturated count", {err_hi, err_lo}, 16'h7FFF);
    run(10);
    check(err_lo == 8'hFF && err_hi == 8'h7F, "R9 holds at max", {err_hi, err_lo}, 16'h7FFF);

    // R10: clear wins over an increment in the same cycle
    clr_cnt = 1; step(); clr_cnt = 0;
    check(err_lo == 8'h80 && err_hi == 8'h00, "R10 clear priority", {err_hi, err_lo}, 16'h0080);
    run(5);
    check(err_lo == 8'h85, "R10 counting resumes after clear", err_lo, 8'h85);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule